// File: doc/BRIEF.md
# Wakeup Interrupt Pending Aggregator

This block gathers the interrupt sources of a low-power domain that can wake the system, and presents them as a bank of 64 pending bits next to a matching bank of enable bits. Bit 0 is a latched non-maskable request. Bits 1 to 15 follow ordinary direct interrupt inputs, and bits 16 to 18 follow direct inputs from peripherals whose interrupts are banked. From bit 19 upward, each bit stands for a group of eight muxed source lines. A group bit is set while any line in its group is high and has its own mux-enable bit set.

The wake output is high when at least one pending bit is set together with its enable bit. Software reaches the block through a plain address, write strobe, write data and read data port. The pending words sit at 0x10 and 0x14, the enable words at 0x40 and 0x44, and the mux-enable words at 0xC0, 0xC4, 0xC8 and 0xCC.

The request latch for bit 0 is a two-state machine. In `NMI_IDLE` the pending bit is clear. The SET transition goes to `NMI_LATCHED` when `nmi_i` is high. The CLEAR transition returns to `NMI_IDLE` on a write of 1 to bit 0 of the first pending word, but only while `nmi_i` is low. A parameter chooses between the reduced set of mux positions and the full set.

Top module: `wpa_wake_agg`

## Requirements
- R1: After reset, the enable word at 0x40 reads 0x00000001, the enable word at 0x44 reads 0, all four mux-enable words read 0, and `wake_o` and `reg_rdata_o` are 0.
- R2: Pending bit 0 (bit 0 of word 0x10) is set by `nmi_i` high at a clock edge. It stays set after `nmi_i` falls. A write to 0x10 with data bit 0 = 1 clears it, unless `nmi_i` is still high at that edge. A write with data bit 0 = 0 leaves it unchanged.
- R3: Pending bits 1 to 18 follow `direct_i[0]` to `direct_i[17]` as levels. Writes to the pending words do not change them.
- R4: Pending bit 19+g (g = 0..15) is the OR, over m = 8g..8g+7, of `mux_src_i[m]` AND mux-enable bit m. Mux-enable bit m is bit m%32 of word 0xC0+4*(m/32), and pending bit k is bit k%32 of word 0x10+4*(k/32).
- R5: The mux-enable words can be written and read back. In the reduced variant (`FULL_MUX`=0), only positions 0–31, 51–95 and 96–99 exist, so the words read back masked by 0xFFFFFFFF, 0xFFF80000, 0xFFFFFFFF and 0x0000000F. Positions that do not exist read 0 and ignore writes.
- R6: The enable words can be written and read back for bits 0 to 34. Enable and pending bits 35 to 63 (word 0x44/0x14 bits 3 to 31) read 0 and ignore writes.
- R7: `wake_o` is 1 in the cycle after a clock edge at which some pending bit and its enable bit are both 1, and 0 otherwise.
- R8: `reg_rdata_o` is registered: after each clock edge it holds the word selected by `reg_addr_i` before that edge. Any address other than the eight mapped words reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Already-conditioned non-maskable request, active high |
| direct_i | input | 18 | Direct sources for pending bits 1 to 18 |
| mux_src_i | input | 128 | Muxed source lines, eight per group |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| wake_o | output | 1 | Registered wake request |

## Verification
The assertions assume that every input is synchronous to `clk`, is stable around each rising edge, and carries no unknown value once reset has been released. They also assume that the write strobe is only raised for one intended word at a time. The stimulus meets these assumptions by changing all inputs just after a falling edge and holding them for at least one full cycle. Each input change is followed by an idle read cycle before any result is compared, so the latch and the registered outputs have settled.

// File: rtl/wpa_pkg.sv
package wpa_pkg;

    // Register word base addresses (byte addresses, word stride 4)
    localparam int PEND_BASE  = 'h10;
    localparam int EN_BASE    = 'h40;
    localparam int MUXEN_BASE = 'hC0;

    // State of the non-maskable request latch
    typedef enum logic {
        NMI_IDLE    = 1'b0,
        NMI_LATCHED = 1'b1
    } nmi_state_e;

    // Existence of a mux position for the selected variant
    function automatic logic mux_pos_valid(input int idx, input bit full);
        return full || (idx < 32) || ((idx >= 51) && (idx < 100));
    endfunction

endpackage

// File: rtl/wpa_nmi_latch.sv
module wpa_nmi_latch
    import wpa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_i,
    input  logic clr_i,
    output logic pend_o
);

    nmi_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= NMI_IDLE;
        else        state_q <= state_d;
    end

    // The set input wins over the clear write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NMI_IDLE:    if (nmi_i)           state_d = NMI_LATCHED;
            NMI_LATCHED: if (clr_i && !nmi_i) state_d = NMI_IDLE;
            default:                          state_d = NMI_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == NMI_LATCHED);
    end

    p_nmi_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_i |=> (state_q == NMI_LATCHED));

    p_nmi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == NMI_LATCHED && !clr_i) |=> (state_q == NMI_LATCHED));

endmodule

// File: rtl/wpa_mux_fold.sv
module wpa_mux_fold #(
    parameter int MUX_BITS = 128,
    parameter int GRP      = 8,
    localparam int NUM_GRP = MUX_BITS / GRP
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MUX_BITS-1:0] src_i,
    input  logic [MUX_BITS-1:0] en_i,
    output logic [NUM_GRP-1:0]  grp_o
);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_fold
        assign grp_o[g] = |(src_i[g*GRP +: GRP] & en_i[g*GRP +: GRP]);

        p_grp_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (en_i[g*GRP +: GRP] == '0) |-> !grp_o[g]);
    end

endmodule

// File: rtl/wpa_regs.sv
module wpa_regs
    import wpa_pkg::*;
#(
    parameter int TOP_BITS  = 64,
    parameter int USED_BITS = 35,
    parameter int MUX_BITS  = 128,
    parameter bit FULL_MUX  = 1'b0,
    parameter int ADDR_W    = 8,
    localparam int TOP_WORDS = TOP_BITS / 32,
    localparam int MUX_WORDS = MUX_BITS / 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic                wr_i,
    input  logic [31:0]         wdata_i,
    output logic [TOP_BITS-1:0] en_o,
    output logic [MUX_BITS-1:0] muxen_o
);

    function automatic logic [MUX_BITS-1:0] mk_mux_mask();
        logic [MUX_BITS-1:0] m;
        for (int i = 0; i < MUX_BITS; i++) m[i] = mux_pos_valid(i, FULL_MUX);
        return m;
    endfunction

    localparam logic [MUX_BITS-1:0] MUX_MASK = mk_mux_mask();
    localparam logic [TOP_BITS-1:0] USED_MASK =
        {{(TOP_BITS-USED_BITS){1'b0}}, {USED_BITS{1'b1}}};

    logic [TOP_BITS-1:0] en_q;
    logic [MUX_BITS-1:0] muxen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= TOP_BITS'(1);
            muxen_q <= '0;
        end else if (wr_i) begin
            for (int w = 0; w < TOP_WORDS; w++) begin
                if (addr_i == ADDR_W'(EN_BASE + 4*w))
                    en_q[w*32 +: 32] <= wdata_i & USED_MASK[w*32 +: 32];
            end
            for (int w = 0; w < MUX_WORDS; w++) begin
                if (addr_i == ADDR_W'(MUXEN_BASE + 4*w))
                    muxen_q[w*32 +: 32] <= wdata_i & MUX_MASK[w*32 +: 32];
            end
        end
    end

    assign en_o    = en_q;
    assign muxen_o = muxen_q;

    p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_q));

    p_muxen_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(muxen_q));

endmodule

// File: rtl/wpa_wake_agg.sv
module wpa_wake_agg
    import wpa_pkg::*;
#(
    parameter int TOP_BITS   = 64,
    parameter int DIRECT_NUM = 18,
    parameter int MUX_BITS   = 128,
    parameter int MUX_GRP    = 8,
    parameter bit FULL_MUX   = 1'b0,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  nmi_i,
    input  logic [DIRECT_NUM-1:0] direct_i,
    input  logic [MUX_BITS-1:0]   mux_src_i,
    input  logic [ADDR_W-1:0]     reg_addr_i,
    input  logic                  reg_wr_i,
    input  logic [31:0]           reg_wdata_i,
    output logic [31:0]           reg_rdata_o,
    output logic                  wake_o
);

    localparam int NUM_GRP   = MUX_BITS / MUX_GRP;
    localparam int USED_BITS = 1 + DIRECT_NUM + NUM_GRP;
    localparam int TOP_WORDS = TOP_BITS / 32;
    localparam int MUX_WORDS = MUX_BITS / 32;

    logic                nmi_pend;
    logic                nmi_clr;
    logic [NUM_GRP-1:0]  grp_pend;
    logic [TOP_BITS-1:0] pend_all;
    logic [TOP_BITS-1:0] en_q;
    logic [MUX_BITS-1:0] muxen_q;
    logic [31:0]         rd_nxt;
    logic                mapped;
    logic [31:0]         rdata_q;
    logic                wake_q;

    assign nmi_clr = reg_wr_i && (reg_addr_i == ADDR_W'(PEND_BASE)) && reg_wdata_i[0];

    wpa_nmi_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_i  (nmi_i),
        .clr_i  (nmi_clr),
        .pend_o (nmi_pend)
    );

    wpa_mux_fold #(
        .MUX_BITS (MUX_BITS),
        .GRP      (MUX_GRP)
    ) u_fold (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (mux_src_i),
        .en_i  (muxen_q),
        .grp_o (grp_pend)
    );

    wpa_regs #(
        .TOP_BITS  (TOP_BITS),
        .USED_BITS (USED_BITS),
        .MUX_BITS  (MUX_BITS),
        .FULL_MUX  (FULL_MUX),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .en_o    (en_q),
        .muxen_o (muxen_q)
    );

    assign pend_all = {{(TOP_BITS-USED_BITS){1'b0}}, grp_pend, direct_i, nmi_pend};

    always_comb begin
        rd_nxt = '0;
        mapped = 1'b0;
        for (int w = 0; w < TOP_WORDS; w++) begin
            if (reg_addr_i == ADDR_W'(PEND_BASE + 4*w)) begin
                rd_nxt = pend_all[w*32 +: 32];
                mapped = 1'b1;
            end
            if (reg_addr_i == ADDR_W'(EN_BASE + 4*w)) begin
                rd_nxt = en_q[w*32 +: 32];
                mapped = 1'b1;
            end
        end
        for (int w = 0; w < MUX_WORDS; w++) begin
            if (reg_addr_i == ADDR_W'(MUXEN_BASE + 4*w)) begin
                rd_nxt = muxen_q[w*32 +: 32];
                mapped = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            wake_q  <= 1'b0;
        end else begin
            rdata_q <= rd_nxt;
            wake_q  <= |(pend_all & en_q);
        end
    end

    assign reg_rdata_o = rdata_q;
    assign wake_o      = wake_q;

    p_wake_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_all & en_q)) |=> wake_o);

    p_wake_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pend_all & en_q)) |=> !wake_o);

    p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |=> (reg_rdata_o == '0));

    p_upper_en_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q[TOP_BITS-1:USED_BITS] == '0));

endmodule

// File: tb/wpa_wake_agg_tb_top.sv
module wpa_wake_agg_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         nmi = 1'b0;
    logic [17:0]  dir = '0;
    logic [127:0] msrc = '0;
    logic [7:0]   addr = '0;
    logic         wr_en = 1'b0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         wake;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0]  m_en;
    logic [127:0] m_mux;
    logic         m_nmi;

    always #5 clk = ~clk;

    wpa_wake_agg dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_i       (nmi),
        .direct_i    (dir),
        .mux_src_i   (msrc),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr_en),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .wake_o      (wake)
    );

    function automatic logic mvalid(int i);
        return (i < 32) || (i >= 51 && i < 100);
    endfunction

    function automatic logic [63:0] exp_pend();
        logic [63:0] p;
        p = '0;
        p[0] = m_nmi;
        for (int i = 0; i < 18; i++) p[1+i] = dir[i];
        for (int g = 0; g < 16; g++) begin
            logic b;
            b = 1'b0;
            for (int k = 0; k < 8; k++) b |= msrc[g*8+k] & m_mux[g*8+k];
            p[19+g] = b;
        end
        return p;
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        logic [63:0] p;
        p = exp_pend();
        case (a)
            8'h10: return p[31:0];
            8'h14: return p[63:32];
            8'h40: return m_en[31:0];
            8'h44: return m_en[63:32];
            8'hC0: return m_mux[31:0];
            8'hC4: return m_mux[63:32];
            8'hC8: return m_mux[95:64];
            8'hCC: return m_mux[127:96];
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_wr(logic [7:0] a, logic [31:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            8'h10: if (d[0] && !nmi) m_nmi = 1'b0;
            8'h40: m_en[31:0]  = d;
            8'h44: m_en[63:32] = d & 32'h7;
            8'hC0, 8'hC4, 8'hC8, 8'hCC: begin
                for (int i = 0; i < 32; i++)
                    m_mux[(a - 8'hC0) * 8 + i] = d[i] & mvalid((a - 8'hC0) * 8 + i);
            end
            default: ;
        endcase
    endtask

    task automatic set_in(logic n, logic [17:0] d, logic [127:0] m);
        nmi  = n;
        dir  = d;
        msrc = m;
        @(negedge clk);
        if (n) m_nmi = 1'b1;
    endtask

    task automatic rd_chk(logic [7:0] a, string tag);
        addr = a;
        @(negedge clk);
        chk(tag, rdata, exp_read(a));
        chk("R7 wake", {31'b0, wake}, {31'b0, |(exp_pend() & m_en)});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] alist [9];
        void'($urandom(32'h5EED_1234));
        alist = '{8'h10, 8'h14, 8'h40, 8'h44, 8'hC0, 8'hC4, 8'hC8, 8'hCC, 8'h20};
        m_en  = 64'h1;
        m_mux = '0;
        m_nmi = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 rdata in reset", rdata, 32'h0);
        chk("R1 wake in reset", {31'b0, wake}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(8'h40, "R1 enable word0");
        chk("R1 enable word0 value", rdata, 32'h1);
        rd_chk(8'h44, "R1 enable word1");
        rd_chk(8'hC0, "R1 muxen0");
        rd_chk(8'hC4, "R1 muxen1");
        rd_chk(8'hC8, "R1 muxen2");
        rd_chk(8'hCC, "R1 muxen3");

        // R2: request latch
        set_in(1'b1, '0, '0);
        set_in(1'b0, '0, '0);
        rd_chk(8'h10, "R2 latched after pulse");
        chk("R2 bit0 held", rdata, 32'h1);
        do_wr(8'h10, 32'hFFFF_FFFE);
        rd_chk(8'h10, "R2 write bit0=0 keeps");
        do_wr(8'h10, 32'h1);
        rd_chk(8'h10, "R2 cleared");
        chk("R2 bit0 clear", rdata, 32'h0);
        set_in(1'b1, '0, '0);
        do_wr(8'h10, 32'h1);
        rd_chk(8'h10, "R2 clear while high loses");
        chk("R2 still set", rdata, 32'h1);
        set_in(1'b0, '0, '0);
        do_wr(8'h10, 32'h1);
        rd_chk(8'h10, "R2 cleared after fall");

        // R3: direct levels, writes ignored
        set_in(1'b0, 18'h2AAAA, '0);
        rd_chk(8'h10, "R3 direct pattern");
        do_wr(8'h10, 32'hFFFF_FFFE);
        rd_chk(8'h10, "R3 write ignored");
        set_in(1'b0, 18'h15555, '0);
        rd_chk(8'h10, "R3 direct inverse");

        // R5: mux-enable valid positions
        do_wr(8'hC4, 32'hFFFF_FFFF);
        rd_chk(8'hC4, "R5 muxen1 masked");
        chk("R5 muxen1 value", rdata, 32'hFFF8_0000);
        do_wr(8'hCC, 32'hFFFF_FFFF);
        rd_chk(8'hCC, "R5 muxen3 masked");
        chk("R5 muxen3 value", rdata, 32'h0000_000F);
        do_wr(8'hC0, 32'h0000_0100);
        rd_chk(8'hC0, "R5 muxen0");

        // R4: group folding
        set_in(1'b0, '0, 128'h1 << 8);
        rd_chk(8'h10, "R4 group1 on");
        chk("R4 bit20", rdata, 32'h0010_0000);
        set_in(1'b0, '0, 128'h1 << 9);
        rd_chk(8'h10, "R4 group1 disabled line");
        set_in(1'b0, '0, 128'h1 << 99);
        rd_chk(8'h10, "R4 group12 edge line");
        chk("R4 bit31", rdata, 32'h8000_0000);
        set_in(1'b0, '0, 128'h1 << 127);
        rd_chk(8'h14, "R4 invalid line 127");

        // R6: enable upper bits
        do_wr(8'h44, 32'hFFFF_FFFF);
        rd_chk(8'h44, "R6 enable word1 masked");
        chk("R6 enable word1 value", rdata, 32'h7);
        do_wr(8'hC8, 32'hFFFF_FFFF);
        set_in(1'b0, '1, '1);
        rd_chk(8'h14, "R6 pending word1 upper zero");
        do_wr(8'h14, 32'hFFFF_FFFF);
        rd_chk(8'h14, "R6 pending word1 write ignored");

        // R8: unmapped addresses
        rd_chk(8'h20, "R8 unmapped 0x20");
        rd_chk(8'h08, "R8 unmapped 0x08");

        // R7: one-cycle wake latency
        do_wr(8'h40, 32'h20);
        do_wr(8'h44, 32'h0);
        do_wr(8'hC0, 32'h0);
        do_wr(8'hC4, 32'h0);
        do_wr(8'hC8, 32'h0);
        do_wr(8'hCC, 32'h0);
        set_in(1'b0, '0, '0);
        rd_chk(8'h40, "R7 setup");
        dir = 18'h10;
        #1;
        chk("R7 wake not before edge", {31'b0, wake}, 32'h0);
        @(negedge clk);
        chk("R7 wake after one edge", {31'b0, wake}, 32'h1);
        dir = 18'h0;
        @(negedge clk);
        chk("R7 wake drops", {31'b0, wake}, 32'h0);

        // Random mix over R2..R8
        for (int it = 0; it < 300; it++) begin
            int act;
            act = $urandom_range(0, 2);
            if (act == 0) begin
                do_wr(alist[$urandom_range(0, 8)], $urandom());
            end else if (act == 1) begin
                set_in(($urandom_range(0, 7) == 0),
                       18'($urandom()),
                       {$urandom(), $urandom(), $urandom(), $urandom()});
            end else begin
                set_in(1'b0, 18'($urandom()) & 18'($urandom()),
                       {$urandom(), $urandom(), $urandom(), $urandom()} &
                       {$urandom(), $urandom(), $urandom(), $urandom()});
            end
            rd_chk(alist[$urandom_range(0, 8)], "R4 R8 random read");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule